// File: doc/BRIEF.md
# Sixteen-bit execute ALU with chained carry and skip compare

This block is the execute stage of a small 16-bit processor. Each issued instruction presents the destination register value, a right-hand operand source (a register value, a short signed immediate, or an immediate widened by a pending prefix) and a 5-bit operation code in the range 16 to 31. For ten of these codes the block returns a result to be written back to the destination register. For the remaining six it compares the two operands and asks the sequencer to skip the next instruction when the condition does not hold.

Multi-word arithmetic is built by chaining. The two carry-producing operations store bit 16 of their 17-bit sum or difference and mark it pending. The next add or subtract of any kind then folds that bit in as carry or borrow. The block keeps the carry bit and the pending flag itself and exposes both, so the sequencer can see that a carry is in flight.

Top module: `skipAlu`

## Requirements
- R1: The right operand is `rsReg` when `useImm` is 0; the sign-extended `imm6` when `useImm` is 1 and `immPend` is 0; and `{immHigh, imm6[3:0]}` when both are 1.
- R2: Code 16 returns rd plus operand plus carry-in, and code 17 returns rd minus operand minus carry-in. The carry-in is the stored carry bit only while the pending flag is set, and 0 otherwise.
- R3: Codes 18 and 19 return the same results as 16 and 17. At the clock edge they store bit 16 of the 17-bit result in `carryOut`, which acts as a borrow for 19, and they set `carryPending`.
- R4: Any valid code 16, 17 or 20 to 25 clears both `carryOut` and `carryPending` at the clock edge. Codes 26 to 31 leave both unchanged.
- R5: Code 20 returns rd XOR operand, 21 returns AND, and 22 returns OR.
- R6: Codes 23, 24 and 25 shift rd left, logically right (zero fill) and arithmetically right (sign fill). The shift amount is taken from operand bits 3:0 only.
- R7: Codes 26 to 31 test eq, ne, signed lt, signed ge, unsigned lt and unsigned ge of rd against the operand. `skipReq` is 1 exactly when the condition is false. `writeEn` stays 0 for these codes.
- R8: `writeEn` is 1 for a valid code 16 to 25. A code below 16 raises neither `writeEn` nor `skipReq` and leaves the carry state unchanged.
- R9: While `rstN` is low, `carryOut` and `carryPending` are 0.
- R10: With `valid` low, `writeEn` and `skipReq` are 0 and the carry state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| valid | input | 1 | an instruction is issued this cycle |
| opcode | input | 5 | operation code |
| rdVal | input | 16 | destination register value, left operand |
| rsReg | input | 16 | source register value |
| useImm | input | 1 | take the operand from the immediate |
| imm6 | input | 6 | signed short immediate |
| immPend | input | 1 | a prefix immediate is pending |
| immHigh | input | 12 | prefix bits for operand bits 15:4 |
| result | output | 16 | value to write to rd |
| writeEn | output | 1 | write `result` to rd |
| skipReq | output | 1 | skip the next instruction |
| carryOut | output | 1 | stored carry bit |
| carryPending | output | 1 | stored carry is used by the next add or subtract |

## Verification
On every cycle the assertions check the carry state: its reset value, that it is set after a carry-producing operation, cleared after a consuming one, and held across compares, idle cycles and unused codes. They also check that skip and write never occur together, and that an arithmetic right shift keeps the sign bit. The actual arithmetic values can only be shown by the bench scenarios. These cover chained carry and borrow, the three operand sources including the prefix splice, shift amounts with the upper bits set, and each compare in both its true and false case.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 16;
  localparam int IMM_W = 6;
  localparam int PFX_W = 12;
  localparam int OP_W = 5;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int LOW_IMM_W = DATA_W - PFX_W;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_XOR, FN_AND, FN_OR, FN_SHL, FN_SHR, FN_ASR
  } aluFnT;

  typedef enum logic [2:0] {
    CMP_EQ, CMP_NE, CMP_LT, CMP_GE, CMP_ULT, CMP_UGE, CMP_NONE
  } cmpFnT;

  typedef struct packed {
    logic  writeRd;
    logic  isCompare;
    logic  setCarry;
    logic  carryIn;
    aluFnT aluFn;
    cmpFnT cmpFn;
  } ctrlStrobeT;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import alu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            valid,
  input  logic [OP_W-1:0] opcode,
  input  logic            carryNext,
  output ctrlStrobeT      strobe,
  output logic            carryReg,
  output logic            carryPend
);
  logic inRange;
  assign inRange = opcode[OP_W-1];

  always_comb begin
    strobe = '{writeRd: 1'b0, isCompare: 1'b0, setCarry: 1'b0, carryIn: 1'b0,
               aluFn: FN_ADD, cmpFn: CMP_NONE};
    if (inRange) begin
      unique case (opcode[3:0])
        4'd0: begin strobe.aluFn = FN_ADD; strobe.writeRd = 1'b1; end
        4'd1: begin strobe.aluFn = FN_SUB; strobe.writeRd = 1'b1; end
        4'd2: begin strobe.aluFn = FN_ADD; strobe.writeRd = 1'b1; strobe.setCarry = 1'b1; end
        4'd3: begin strobe.aluFn = FN_SUB; strobe.writeRd = 1'b1; strobe.setCarry = 1'b1; end
        4'd4: begin strobe.aluFn = FN_XOR; strobe.writeRd = 1'b1; end
        4'd5: begin strobe.aluFn = FN_AND; strobe.writeRd = 1'b1; end
        4'd6: begin strobe.aluFn = FN_OR;  strobe.writeRd = 1'b1; end
        4'd7: begin strobe.aluFn = FN_SHL; strobe.writeRd = 1'b1; end
        4'd8: begin strobe.aluFn = FN_SHR; strobe.writeRd = 1'b1; end
        4'd9: begin strobe.aluFn = FN_ASR; strobe.writeRd = 1'b1; end
        4'd10: begin strobe.cmpFn = CMP_EQ;  strobe.isCompare = 1'b1; end
        4'd11: begin strobe.cmpFn = CMP_NE;  strobe.isCompare = 1'b1; end
        4'd12: begin strobe.cmpFn = CMP_LT;  strobe.isCompare = 1'b1; end
        4'd13: begin strobe.cmpFn = CMP_GE;  strobe.isCompare = 1'b1; end
        4'd14: begin strobe.cmpFn = CMP_ULT; strobe.isCompare = 1'b1; end
        default: begin strobe.cmpFn = CMP_UGE; strobe.isCompare = 1'b1; end
      endcase
    end
    strobe.carryIn = carryPend & carryReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryReg  <= 1'b0;
      carryPend <= 1'b0;
    end else if (valid && strobe.writeRd) begin
      carryReg  <= strobe.setCarry & carryNext;
      carryPend <= strobe.setCarry;
    end
  end

  // R9
  a_r9_reset_clear: assert property (@(posedge clk) !rstN |=> (!carryReg && !carryPend));
  // R3
  a_r3_pend_set: assert property (@(posedge clk) disable iff (!rstN)
    (valid && strobe.setCarry) |=> carryPend);
  // R4
  a_r4_consume_clear: assert property (@(posedge clk) disable iff (!rstN)
    (valid && strobe.writeRd && !strobe.setCarry) |=> (!carryPend && !carryReg));
  // R4
  a_r4_cmp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (valid && strobe.isCompare) |=> ($stable(carryPend) && $stable(carryReg)));
  // R10
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> ($stable(carryPend) && $stable(carryReg)));
  // R8
  a_r8_low_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !inRange) |=> ($stable(carryPend) && $stable(carryReg)));
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [DATA_W-1:0] rdVal,
  input  logic [DATA_W-1:0] rsReg,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  imm6,
  input  logic              immPend,
  input  logic [PFX_W-1:0]  immHigh,
  output logic [DATA_W-1:0] result,
  output logic              carryNext,
  output logic              condTrue
);
  logic [DATA_W-1:0]  rsVal;
  logic [DATA_W:0]    sumWide;
  logic [SHAMT_W-1:0] shAmt;
  logic               isSub;

  always_comb begin
    if (!useImm)      rsVal = rsReg;
    else if (immPend) rsVal = {immHigh, imm6[LOW_IMM_W-1:0]};
    else              rsVal = {{(DATA_W-IMM_W){imm6[IMM_W-1]}}, imm6};
  end

  assign isSub = (strobe.aluFn == FN_SUB);
  assign shAmt = rsVal[SHAMT_W-1:0];

  always_comb begin
    if (isSub) sumWide = {1'b0, rdVal} - {1'b0, rsVal} - {{DATA_W{1'b0}}, strobe.carryIn};
    else       sumWide = {1'b0, rdVal} + {1'b0, rsVal} + {{DATA_W{1'b0}}, strobe.carryIn};
  end
  assign carryNext = sumWide[DATA_W];

  always_comb begin
    unique case (strobe.aluFn)
      FN_ADD, FN_SUB: result = sumWide[DATA_W-1:0];
      FN_XOR: result = rdVal ^ rsVal;
      FN_AND: result = rdVal & rsVal;
      FN_OR:  result = rdVal | rsVal;
      FN_SHL: result = rdVal << shAmt;
      FN_SHR: result = rdVal >> shAmt;
      default: result = DATA_W'($signed(rdVal) >>> shAmt);
    endcase
  end

  always_comb begin
    unique case (strobe.cmpFn)
      CMP_EQ:  condTrue = (rdVal == rsVal);
      CMP_NE:  condTrue = (rdVal != rsVal);
      CMP_LT:  condTrue = ($signed(rdVal) < $signed(rsVal));
      CMP_GE:  condTrue = ($signed(rdVal) >= $signed(rsVal));
      CMP_ULT: condTrue = (rdVal < rsVal);
      CMP_UGE: condTrue = (rdVal >= rsVal);
      default: condTrue = 1'b1;
    endcase
  end

  // R6: arithmetic right shift keeps the sign of rd
  a_r6_asr_sign: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeRd && strobe.aluFn == FN_ASR) |-> (result[DATA_W-1] == rdVal[DATA_W-1]));
  // R6: logical right shift by a nonzero amount clears the top bit
  a_r6_shr_fill: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeRd && strobe.aluFn == FN_SHR && rsVal[SHAMT_W-1:0] != '0) |-> !result[DATA_W-1]);
endmodule

// File: rtl/skipAlu.sv
module skipAlu
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] rdVal,
  input  logic [DATA_W-1:0] rsReg,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  imm6,
  input  logic              immPend,
  input  logic [PFX_W-1:0]  immHigh,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              skipReq,
  output logic              carryOut,
  output logic              carryPending
);
  ctrlStrobeT strobe;
  logic carryNext;
  logic condTrue;

  aluCtrl ctrl (
    .clk(clk), .rstN(rstN), .valid(valid), .opcode(opcode),
    .carryNext(carryNext), .strobe(strobe),
    .carryReg(carryOut), .carryPend(carryPending)
  );

  aluDatapath dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdVal(rdVal), .rsReg(rsReg),
    .useImm(useImm), .imm6(imm6), .immPend(immPend), .immHigh(immHigh),
    .result(result), .carryNext(carryNext), .condTrue(condTrue)
  );

  assign writeEn = valid & strobe.writeRd;
  assign skipReq = valid & strobe.isCompare & ~condTrue;

  // R7
  a_r7_skip_excl_write: assert property (@(posedge clk) disable iff (!rstN)
    !(skipReq && writeEn));
  // R10
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> (!writeEn && !skipReq));
endmodule

// File: tb/skipAlu_test.sv
`timescale 1ns/1ps
module skipAlu_test;
  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] rd;
    logic [15:0] rs;
    logic        ui;
    logic [5:0]  im;
    logic        ip;
    logic [11:0] ih;
    logic [15:0] expRes;
    logic        expWe;
    logic        expSkip;
    logic        expC;
    logic        expP;
  } vecT;

  localparam int NV = 23;
  localparam vecT VECS [NV] = '{
    '{5'd16, 16'h1234, 16'h0101, 1'b0, 6'h00, 1'b0, 12'h000, 16'h1335, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 add, R1 register
    '{5'd17, 16'h0010, 16'h0000, 1'b1, 6'h3F, 1'b0, 12'h000, 16'h0011, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 sub, R1 sext imm
    '{5'd18, 16'hFFFF, 16'h0002, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 addc carry
    '{5'd16, 16'h0001, 16'h0001, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 carry used, R4 clear
    '{5'd19, 16'h0000, 16'h0001, 1'b0, 6'h00, 1'b0, 12'h000, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 subc borrow
    '{5'd26, 16'h0005, 16'h0005, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 eq true, R4 hold
    '{5'd17, 16'h0010, 16'h0001, 1'b0, 6'h00, 1'b0, 12'h000, 16'h000E, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 borrow used
    '{5'd20, 16'h00FF, 16'h0000, 1'b1, 6'h05, 1'b1, 12'hABC, 16'hAB3A, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 xor, R1 prefix
    '{5'd21, 16'hF0F0, 16'h3C3C, 1'b0, 6'h00, 1'b0, 12'h000, 16'h3030, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 and
    '{5'd22, 16'h0F00, 16'h0000, 1'b1, 6'h20, 1'b0, 12'h000, 16'hFFE0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 or, R1 negative imm
    '{5'd23, 16'h0001, 16'h0013, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0008, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 shl low 4 bits
    '{5'd24, 16'h8000, 16'h000F, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 shr zero fill
    '{5'd25, 16'h8000, 16'h0004, 1'b0, 6'h00, 1'b0, 12'h000, 16'hF800, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 asr sign fill
    '{5'd27, 16'h0003, 16'h0003, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 ne false
    '{5'd28, 16'hFFFF, 16'h0001, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 lt true
    '{5'd29, 16'hFFFF, 16'h0001, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 ge false
    '{5'd30, 16'hFFFF, 16'h0001, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 ult false
    '{5'd31, 16'hFFFF, 16'h0001, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 uge true
    '{5'd18, 16'h8000, 16'h8000, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 addc
    '{5'd5,  16'h0000, 16'h0000, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 low code ignored
    '{5'd16, 16'h0000, 16'h0000, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 carry survives
    '{5'd19, 16'h0005, 16'h0003, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 subc no borrow
    '{5'd21, 16'hFFFF, 16'h00FF, 1'b0, 6'h00, 1'b0, 12'h000, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b0}  // R4 logic clears
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic valid = 1'b0;
  logic [4:0] opcode = '0;
  logic [15:0] rdVal = '0, rsReg = '0;
  logic useImm = 1'b0, immPend = 1'b0;
  logic [5:0] imm6 = '0;
  logic [11:0] immHigh = '0;
  logic [15:0] result;
  logic writeEn, skipReq, carryOut, carryPending;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  skipAlu uut (
    .clk(clk), .rstN(rstN), .valid(valid), .opcode(opcode), .rdVal(rdVal),
    .rsReg(rsReg), .useImm(useImm), .imm6(imm6), .immPend(immPend),
    .immHigh(immHigh), .result(result), .writeEn(writeEn), .skipReq(skipReq),
    .carryOut(carryOut), .carryPending(carryPending)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runVec(input vecT v, input int idx);
    @(negedge clk);
    valid = 1'b1; opcode = v.op; rdVal = v.rd; rsReg = v.rs;
    useImm = v.ui; imm6 = v.im; immPend = v.ip; immHigh = v.ih;
    #1;
    if (v.expWe) chk($sformatf("R2/R5/R6 result vec %0d", idx), result, v.expRes);
    chk($sformatf("R8 writeEn vec %0d", idx), {15'd0, writeEn}, {15'd0, v.expWe});
    chk($sformatf("R7 skipReq vec %0d", idx), {15'd0, skipReq}, {15'd0, v.expSkip});
    @(posedge clk); #1;
    chk($sformatf("R3/R4 carryOut vec %0d", idx), {15'd0, carryOut}, {15'd0, v.expC});
    chk($sformatf("R3/R4 carryPending vec %0d", idx), {15'd0, carryPending}, {15'd0, v.expP});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: state during reset
    repeat (2) @(posedge clk);
    #1;
    chk("R9 carryOut in reset", {15'd0, carryOut}, 16'd0);
    chk("R9 carryPending in reset", {15'd0, carryPending}, 16'd0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R10: idle cycle with carry pending holds state and stays quiet
    runVec('{5'd18, 16'hFFFF, 16'h0001, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1}, 100);
    @(negedge clk);
    valid = 1'b0; opcode = 5'd26; rdVal = 16'h0001; rsReg = 16'h0002;
    #1;
    chk("R10 writeEn idle", {15'd0, writeEn}, 16'd0);
    chk("R10 skipReq idle", {15'd0, skipReq}, 16'd0);
    @(posedge clk); #1;
    chk("R10 carryOut idle", {15'd0, carryOut}, 16'd1);
    chk("R10 carryPending idle", {15'd0, carryPending}, 16'd1);

    // R1: prefix ignored when the register operand is selected
    runVec('{5'd16, 16'h0000, 16'h0100, 1'b0, 6'h3F, 1'b1, 12'hFFF, 16'h0101, 1'b1, 1'b0, 1'b0, 1'b0}, 101);

    // R9: reset in mid-run clears a pending carry
    runVec('{5'd18, 16'hFFFF, 16'hFFFF, 1'b0, 6'h00, 1'b0, 12'h000, 16'hFFFE, 1'b1, 1'b0, 1'b1, 1'b1}, 102);
    @(negedge clk); valid = 1'b0; rstN = 1'b0;
    #1;
    chk("R9 carryOut after reset", {15'd0, carryOut}, 16'd0);
    chk("R9 carryPending after reset", {15'd0, carryPending}, 16'd0);
    @(negedge clk); rstN = 1'b1;
    runVec('{5'd16, 16'h0002, 16'h0003, 1'b0, 6'h00, 1'b0, 12'h000, 16'h0005, 1'b1, 1'b0, 1'b0, 1'b0}, 103);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule